// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Atomic Set/Clear

This block is a general-purpose I/O controller that sits on a simple synchronous register bus. The bus has an address, a write strobe, write data, a read strobe and read data. The controller holds an output-value register and a direction register. It drives the output values and the per-line output enables toward the pin buffers. It also samples the input pins through a two-flop synchronizer. Software changes individual lines without a read-modify-write by writing ones to a set address or to a clear address. It can also load every output at once through the data address.

Three parameters shape the block. The register width, which is also the line count, is 8, 16, 32 or 64. The polarity of the direction register can be chosen, so that a one marks an output or a one marks an input. The numbering from register bit to pin can be reversed. A fourth parameter removes the clear address. In that variant the set address holds the complete output value and reads back what was last written.

Top module: `gpio_setclr`

## Requirements
- R1: After reset the output-value and direction registers are zero, so pin_out is all zeros. With a one meaning output, pin_oe is all zeros; with a one meaning input, pin_oe is all ones. bus_rdata is zero.
- R2: Register addresses are 0 = data, 1 = set, 2 = clear, 3 = direction. A write to address 0 loads all output values at once, visible on pin_out after the write edge. Without a write strobe, no register changes.
- R3: With the clear address present, a write to address 1 drives high every output bit whose write-data bit is 1 and keeps all other bits.
- R4: With the clear address present, a write to address 2 drives low every output bit whose write-data bit is 1 and keeps all other bits.
- R5: With DIR_IS_INPUT = 0, a 1 in direction bit n enables the output driver of that line (pin_oe = 1) and a 0 makes it an input.
- R6: With DIR_IS_INPUT = 1 the sense inverts: a 1 in direction bit n makes the line an input (pin_oe = 0) and a 0 makes it an output.
- R7: A read of address 0 returns, per bit, the driven output value for output lines and the synchronized pin value for input lines. A pin change made before rising edge k is first seen by a read strobe sampled at edge k+2.
- R8: With REVERSE_BITS = 1, line n corresponds to register bit WIDTH-1-n in every register (output value, direction, data read); otherwise line n is bit n.
- R9: With HAS_CLEAR = 0, a write to address 1 loads the full output value, and a read of address 1 returns the last value loaded. Writes to address 2 have no effect.
- R10: Read data is returned on bus_rdata in the cycle after the read strobe and is zero in any cycle without a preceding read strobe. Reads of address 1 (when the clear address is present) and of address 2 return zero.
- R11: A read of address 3 returns the direction register as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Read data, registered |
| pin_in | input | WIDTH | Asynchronous input pin levels |
| pin_out | output | WIDTH | Output values to pin buffers |
| pin_oe | output | WIDTH | Output enables to pin buffers |

## Verification
A wrong bit in the output-value register shows on pin_out right after the edge that follows the bus write. A wrong bit in the direction register shows on pin_oe in the same way, so bit-level slips in set or clear masking surface within one cycle. Faults in bit reversal or direction polarity appear at the pins of a second instance that uses the opposite settings. Faults in the synchronizer depth or the read multiplexer appear only at bus_rdata, one cycle after a read strobe. The bench therefore reads the data address on three consecutive edges after a pin change, to pin the exact cycle in which a new input level becomes visible.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_DIR  = 2'd3
    } reg_sel_e;

    localparam int SYNC_DEPTH = 2;

    function automatic bit legal_width(input int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

endpackage

// File: rtl/gpio_bitmap.sv
module gpio_bitmap #(
    parameter int WIDTH   = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    generate
        if (REVERSE) begin : g_rev
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign dst[i] = src[WIDTH-1-i];
            end
        end else begin : g_straight
            assign dst = src;
        end
    endgenerate
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter bit HAS_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr) begin
            case (sel)
                REG_DATA: out_q <= wdata;
                REG_SET:  out_q <= HAS_CLEAR ? (out_q | wdata) : wdata;
                REG_CLR:  if (HAS_CLEAR) out_q <= out_q & ~wdata;
                REG_DIR:  dir_q <= wdata;
                default:  ;
            endcase
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(out_q) && $stable(dir_q)));

    // R3
    set_bits_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    generate
        if (HAS_CLEAR) begin : g_clr_chk
            // R4
            clr_bits_low_chk: assert property (@(posedge clk) disable iff (rst)
                (wr && sel == REG_CLR) |=> ((out_q & $past(wdata)) == '0));
        end else begin : g_noclr_chk
            // R9
            clr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                (wr && sel == REG_CLR) |=> $stable(out_q));
        end
    endgenerate
endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr
    import gpio_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter bit DIR_IS_INPUT = 1'b0,
    parameter bit REVERSE_BITS = 1'b0,
    parameter bit HAS_CLEAR    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_rd,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    generate
        if (!legal_width(WIDTH)) begin : g_bad_width
            $error("gpio_setclr: WIDTH must be 8, 16, 32 or 64");
        end
    endgenerate

    reg_sel_e         sel;
    logic [WIDTH-1:0] out_q, dir_q, drive_en, in_sync, in_reg, data_view, set_view;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.WIDTH(WIDTH), .HAS_CLEAR(HAS_CLEAR)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
        .out_q(out_q), .dir_q(dir_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(in_sync)
    );

    assign drive_en = DIR_IS_INPUT ? ~dir_q : dir_q;

    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSE_BITS)) u_map_in (
        .src(in_sync), .dst(in_reg)
    );
    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSE_BITS)) u_map_out (
        .src(out_q), .dst(pin_out)
    );
    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSE_BITS)) u_map_oe (
        .src(drive_en), .dst(pin_oe)
    );

    assign data_view = (drive_en & out_q) | (~drive_en & in_reg);
    assign set_view  = HAS_CLEAR ? '0 : out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                REG_DATA: bus_rdata <= data_view;
                REG_SET:  bus_rdata <= set_view;
                REG_DIR:  bus_rdata <= dir_q;
                default:  bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    // R10
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    // R11
    dir_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == $past(dir_q)));

    // R10
    clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_setclr.sv
`timescale 1ns/1ps
module sim_gpio_setclr;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // u0: 32 lines, one means output, straight numbering, clear present
    logic [1:0]  a0 = '0;
    logic        w0 = 1'b0, r0 = 1'b0;
    logic [31:0] wd0 = '0, rd0, pi0 = '0, po0, oe0;

    // u1: 8 lines, one means input, reversed numbering, no clear address
    logic [1:0]  a1 = '0;
    logic        w1 = 1'b0, r1 = 1'b0;
    logic [7:0]  wd1 = '0, rd1, pi1 = '0, po1, oe1;

    gpio_setclr #(.WIDTH(32), .DIR_IS_INPUT(1'b0), .REVERSE_BITS(1'b0), .HAS_CLEAR(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_addr(a0), .bus_wr(w0), .bus_wdata(wd0),
        .bus_rd(r0), .bus_rdata(rd0), .pin_in(pi0), .pin_out(po0), .pin_oe(oe0)
    );

    gpio_setclr #(.WIDTH(8), .DIR_IS_INPUT(1'b1), .REVERSE_BITS(1'b1), .HAS_CLEAR(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_addr(a1), .bus_wr(w1), .bus_wdata(wd1),
        .bus_rd(r1), .bus_rdata(rd1), .pin_in(pi1), .pin_out(po1), .pin_oe(oe1)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr0(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); a0 = a; wd0 = d; w0 = 1'b1;
        @(negedge clk); w0 = 1'b0;
    endtask

    task automatic rdx0(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); a0 = a; r0 = 1'b1;
        @(negedge clk); r0 = 1'b0; v = rd0;
    endtask

    task automatic wr1(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); a1 = a; wd1 = d; w1 = 1'b1;
        @(negedge clk); w1 = 1'b0;
    endtask

    task automatic rdx1(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); a1 = a; r1 = 1'b1;
        @(negedge clk); r1 = 1'b0; v = rd1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 u0 pin_out", po0, 0);
        check("R1 u0 pin_oe", oe0, 0);
        check("R1 u0 rdata", rd0, 0);
        check("R1 u1 pin_out", po1, 0);
        check("R1 u1 pin_oe all ones", oe1, 8'hFF);
        rdx0(2'd0, v);
        check("R1/R7 u0 data read after reset", v, 32'h1234_5678);
    endtask

    task automatic t_main_u0();
        logic [31:0] v;
        wr0(2'd0, 32'hA5A5_0F0F);
        check("R2 data write", po0, 32'hA5A5_0F0F);
        check("R5 still inputs", oe0, 0);
        rdx0(2'd0, v);
        check("R7 all inputs read pins", v, 32'h1234_5678);
        wr0(2'd3, 32'hFFFF_0000);
        check("R5 dir one drives", oe0, 32'hFFFF_0000);
        rdx0(2'd3, v);
        check("R11 dir readback", v, 32'hFFFF_0000);
        rdx0(2'd0, v);
        check("R7 mixed read", v, 32'hA5A5_5678);
        wr0(2'd1, 32'h0000_00F0);
        check("R3 set", po0, 32'hA5A5_0FFF);
        wr0(2'd2, 32'h0000_0F0F);
        check("R4 clear", po0, 32'hA5A5_00F0);
        wr0(2'd2, 32'hA000_0000);
        check("R4 clear upper", po0, 32'h05A5_00F0);
        rdx0(2'd1, v);
        check("R10 set reads zero", v, 0);
        rdx0(2'd2, v);
        check("R10 clear reads zero", v, 0);
        @(negedge clk);
        check("R10 idle rdata zero", rd0, 0);
        check("R2 no write no change", po0, 32'h05A5_00F0);
    endtask

    task automatic t_sync_u0();
        @(negedge clk); pi0 = 32'h0000_FFFF; a0 = 2'd0; r0 = 1'b1;
        @(negedge clk);
        check("R7 sync edge1 old", rd0, 32'h05A5_5678);
        @(negedge clk);
        check("R7 sync edge2 old", rd0, 32'h05A5_5678);
        @(negedge clk); r0 = 1'b0;
        check("R7 sync edge3 new", rd0, 32'h05A5_FFFF);
    endtask

    task automatic t_u1();
        logic [7:0] v;
        wr1(2'd1, 8'h01);
        check("R8/R9 set loads reversed", po1, 8'h80);
        rdx1(2'd1, v);
        check("R9 set readback", v, 8'h01);
        rdx1(2'd0, v);
        check("R6 outputs read driven", v, 8'h01);
        wr1(2'd0, 8'h03);
        check("R2/R8 data reversed", po1, 8'hC0);
        wr1(2'd2, 8'hFF);
        check("R9 clear ignored", po1, 8'hC0);
        rdx1(2'd2, v);
        check("R10 clear addr reads zero", v, 0);
        wr1(2'd3, 8'h0F);
        check("R6/R8 dir one is input", oe1, 8'h0F);
        rdx1(2'd0, v);
        check("R7/R8 reversed input read", v, 8'h05);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        pi0 = 32'h1234_5678;
        pi1 = 8'hA0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_main_u0();
        t_sync_u0();
        t_u1();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule